// File: doc/BRIEF.md
# Serial EEPROM Sequential Byte Reader

This block fetches a run of bytes from a small serial EEPROM over a four-wire SPI-style link. Typical contents are a stored station address or board identity. The host gives one start pulse with a starting byte offset and a byte count. The block then runs one complete chip-select framed transaction for each byte: an 8-bit read command, the 8-bit offset, and eight received data bits. The offset advances by one between transactions. Each byte comes back on `byte_data` with a one-cycle `byte_valid` strobe, and a `done` pulse closes the request.

The serial clock is much slower than the system clock. Every half-phase of the serial clock lasts `HALF_CYC` system cycles, counted by a pacing counter. The first request after reset is preceded by two clock pulses with chip select inactive, to bring the device out of power-up. A status mode replaces the read command with the status command and skips the address phase.

Top module: `eeprom_seq_reader`

## Requirements
- R1: After reset, and whenever no request is running, `ee_cs_n` is 1, `ee_sck` is 0 and `busy` is 0.
- R2: In read mode each transaction first shifts out the command 0x03 and then the 8-bit offset, both MSB first, on `ee_sdo`. `ee_sdo` changes only while `ee_sck` is low, so the device captures each bit on a rising edge.
- R3: After the address the block gives 8 more clock pulses with `ee_sdo` at 0. It samples `ee_sdi` at the end of the low half that precedes each of these pulses and assembles the byte MSB first. The byte appears on `byte_data` during a `byte_valid` pulse that lasts exactly one cycle.
- R4: The high half of each serial clock pulse lasts `HALF_CYC` system cycles. Successive rising edges within a transaction are `2*HALF_CYC` cycles apart.
- R5: Each transaction ends with `ee_cs_n` rising while `ee_sck` is 0. Within a request, chip select then stays high for exactly `GAP_HALVES*HALF_CYC` cycles before the next transaction.
- R6: A request with count N runs N transactions, at offsets offset, offset+1, and so on, modulo 256 (0xFF is followed by 0x00).
- R7: Before the first transaction after reset the block gives exactly two `ee_sck` pulses with `ee_cs_n` high. Later requests give none.
- R8: When `status_mode` is 1 at start, each transaction sends the command 0x05, has no address phase (16 clocks in total), and receives one byte.
- R9: `done` is a one-cycle pulse that comes after the last `byte_valid` of the request, in the cycle where `busy` has returned to 0.
- R10: A start with count 0 causes no serial activity and asserts `done` in the cycle after the start, with `busy` held at 0.
- R11: A `start` pulse while `busy` is 1 is ignored: it changes neither the byte stream nor the number of `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| status_mode | input | 1 | 1 selects status-register reads |
| offset | input | 8 | First byte offset |
| count | input | 8 | Number of bytes to read |
| busy | output | 1 | Request in progress |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_data | output | 8 | Received byte |
| done | output | 1 | Request finished |
| ee_cs_n | output | 1 | Device chip select, active low |
| ee_sck | output | 1 | Serial clock |
| ee_sdo | output | 1 | Serial data to the device |
| ee_sdi | input | 1 | Serial data from the device |

## Verification
The hardest situations to reach are the one-time power-up preamble and the offset wrap. The preamble happens once per reset, so the bench first issues a zero-count request, which must not consume the preamble. It then issues the first real read and counts the clock pulses seen with chip select high, both then and after every later request. The wrap needs a multi-byte request that starts at 0xFE. An EEPROM model in the bench decodes each framed command and address, and the scoreboard compares them with the offsets expected after the wrap.

// File: rtl/eepr_pkg.sv
package eepr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_XFER,
        ST_GAP
    } seq_state_e;

    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_STATUS = 8'h05;
endpackage

// File: rtl/eepr_pacer.sv
module eepr_pacer #(
    parameter int HALF_CYC = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)               cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == LAST);

    // R4: every half-phase advances one count per cycle until its end
    a_r4_pace_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/eepr_shift.sv
module eepr_shift #(
    parameter int FW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] frame,
    input  logic          adv,
    input  logic          cap,
    input  logic          sdi,
    output logic          sdo_bit,
    output logic [7:0]    rx_byte
);
    typedef struct packed {
        logic [FW-1:0] tx;
        logic [7:0]    rx;
    } shift_t;

    shift_t d, q;

    always_comb begin
        d = q;
        if (load) begin
            d.tx = frame;
            d.rx = '0;
        end else begin
            if (adv) d.tx = {q.tx[FW-2:0], 1'b0};
            if (cap) d.rx = {q.rx[6:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo_bit = q.tx[FW-1];
    assign rx_byte = q.rx;

    // R3: a fresh frame never starts with stale received bits
    a_r3_rx_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q.rx == 8'h00));
endmodule

// File: rtl/eeprom_seq_reader.sv
module eeprom_seq_reader
    import eepr_pkg::*;
#(
    parameter int HALF_CYC   = 625,
    parameter int GAP_HALVES = 2,
    parameter int PRE_PULSES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       status_mode,
    input  logic [7:0] offset,
    input  logic [7:0] count,
    output logic       busy,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       done,
    output logic       ee_cs_n,
    output logic       ee_sck,
    output logic       ee_sdo,
    input  logic       ee_sdi
);
    localparam int FRAME_BITS = 24;
    localparam int STAT_BITS  = 16;
    localparam int M1 = (2 * FRAME_BITS > 2 * PRE_PULSES) ? 2 * FRAME_BITS : 2 * PRE_PULSES;
    localparam int HALF_MAX = (M1 > GAP_HALVES) ? M1 : GAP_HALVES;
    localparam int HW = $clog2(HALF_MAX + 1);
    localparam logic [HW-1:0] PRE_LAST  = HW'(2 * PRE_PULSES - 1);
    localparam logic [HW-1:0] GAP_LAST  = HW'(GAP_HALVES - 1);
    localparam logic [HW-1:0] RD_LAST   = HW'(2 * FRAME_BITS - 1);
    localparam logic [HW-1:0] ST_LAST   = HW'(2 * STAT_BITS - 1);
    localparam logic [HW-1:0] RD_DATA0  = HW'(2 * (FRAME_BITS - 8));
    localparam logic [HW-1:0] ST_DATA0  = HW'(2 * (STAT_BITS - 8));

    typedef struct packed {
        seq_state_e    st;
        logic [HW-1:0] half;
        logic          primed;
        logic          stat;
        logic [7:0]    addr;
        logic [7:0]    remain;
        logic          cs_n;
        logic          sck;
        logic          bvalid;
        logic [7:0]    bdata;
        logic          done;
    } seq_t;

    seq_t d, q;

    logic                  tick;
    logic                  load, adv, cap;
    logic [FRAME_BITS-1:0] frame;
    logic                  sdo_bit;
    logic [7:0]            rx_byte;
    logic [HW-1:0]         last_half, data_half;

    eepr_pacer #(.HALF_CYC(HALF_CYC)) u_pacer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.st != ST_IDLE),
        .tick (tick)
    );

    eepr_shift #(.FW(FRAME_BITS)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .frame  (frame),
        .adv    (adv),
        .cap    (cap),
        .sdi    (ee_sdi),
        .sdo_bit(sdo_bit),
        .rx_byte(rx_byte)
    );

    always_comb begin
        d         = q;
        d.bvalid  = 1'b0;
        d.done    = 1'b0;
        load      = 1'b0;
        adv       = 1'b0;
        cap       = 1'b0;
        last_half = q.stat ? ST_LAST : RD_LAST;
        data_half = q.stat ? ST_DATA0 : RD_DATA0;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (count == 8'd0) begin
                        d.done = 1'b1;
                    end else begin
                        d.remain = count;
                        d.addr   = offset;
                        d.stat   = status_mode;
                        d.half   = '0;
                        if (!q.primed) begin
                            d.st  = ST_PRE;
                            d.sck = 1'b1;
                        end else begin
                            d.st   = ST_XFER;
                            d.cs_n = 1'b0;
                            d.sck  = 1'b0;
                            load   = 1'b1;
                        end
                    end
                end
            end
            ST_PRE: begin
                if (tick) begin
                    if (q.half == PRE_LAST) begin
                        d.primed = 1'b1;
                        d.st     = ST_XFER;
                        d.cs_n   = 1'b0;
                        d.sck    = 1'b0;
                        d.half   = '0;
                        load     = 1'b1;
                    end else begin
                        d.half = q.half + 1'b1;
                        d.sck  = ~q.sck;
                    end
                end
            end
            ST_XFER: begin
                if (tick) begin
                    if (!q.half[0]) begin
                        d.sck  = 1'b1;
                        cap    = (q.half >= data_half);
                        d.half = q.half + 1'b1;
                    end else begin
                        d.sck = 1'b0;
                        adv   = 1'b1;
                        if (q.half == last_half) begin
                            d.cs_n   = 1'b1;
                            d.bvalid = 1'b1;
                            d.bdata  = rx_byte;
                            d.st     = ST_GAP;
                            d.half   = '0;
                            d.remain = q.remain - 8'd1;
                            d.addr   = q.addr + 8'd1;
                        end else begin
                            d.half = q.half + 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (q.half == GAP_LAST) begin
                        d.half = '0;
                        if (q.remain == 8'd0) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.st   = ST_XFER;
                            d.cs_n = 1'b0;
                            load   = 1'b1;
                        end
                    end else begin
                        d.half = q.half + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        frame = d.stat ? {OP_STATUS, 16'h0000} : {OP_READ, d.addr, 8'h00};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st != ST_IDLE);
    assign byte_valid = q.bvalid;
    assign byte_data  = q.bdata;
    assign done       = q.done;
    assign ee_cs_n    = q.cs_n;
    assign ee_sck     = q.sck;
    assign ee_sdo     = ~q.cs_n & sdo_bit;

    // R1: idle lines
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ee_cs_n && !ee_sck));
    // R2: outgoing data holds while the clock is high
    a_r2_sdo_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sck && $past(ee_sck)) |-> $stable(ee_sdo));
    // R3: byte strobe is a single cycle
    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);
    // R5: chip select releases only with the clock low
    a_r5_cs_rise_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs_n) |-> !ee_sck);
    // R9: completion coincides with idle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R10: empty request completes at once
    a_r10_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && count == 8'd0) |=> (done && !busy));
endmodule

// File: tb/eeprom_seq_reader_bench.sv
module eeprom_seq_reader_bench;
    localparam int HALF = 4;
    localparam int GAP  = 2;
    localparam logic [7:0] STATUS_VAL = 8'hC6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       status_mode = 1'b0;
    logic [7:0] offset = 8'h00;
    logic [7:0] count = 8'h00;
    logic       busy, byte_valid, done, ee_cs_n, ee_sck, ee_sdo;
    logic [7:0] byte_data;
    logic       ee_sdi = 1'b0;

    always #4 clk = ~clk;

    eeprom_seq_reader #(.HALF_CYC(HALF), .GAP_HALVES(GAP), .PRE_PULSES(2)) u_eeprom_seq_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .status_mode(status_mode),
        .offset(offset), .count(count), .busy(busy), .byte_valid(byte_valid),
        .byte_data(byte_data), .done(done), .ee_cs_n(ee_cs_n), .ee_sck(ee_sck),
        .ee_sdo(ee_sdo), .ee_sdi(ee_sdi)
    );

    int compared = 0;
    int mismatched = 0;
    int done_cnt = 0;
    int pre_cnt = 0;
    bit finished = 0;

    int exp_byte_q[$];
    int exp_op_q[$];
    int exp_ad_q[$];

    function automatic logic [7:0] mem_f(input logic [7:0] a);
        return (a * 8'd37) ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // EEPROM model and serial-side monitor, evaluated away from the active edge
    logic       sck_r = 1'b0, cs_r = 1'b1;
    int         nbit = 0, dbit = 0, cyc = 0, t_rise = -1, t_fall = 0, t_csr = 0;
    logic [7:0] op = 0, ad = 0, dout = 0;
    bit         gap_live = 0;

    always @(negedge clk) begin
        cyc++;
        if (!busy) gap_live = 0;
        if (cs_r && !ee_cs_n) begin
            if (gap_live)
                chk(cyc - t_csr == GAP * HALF, "R5", "gap length", cyc - t_csr, GAP * HALF);
            nbit = 0; dbit = 0; op = 0; ad = 0; t_rise = -1;
        end
        if (!ee_cs_n && !sck_r && ee_sck) begin
            if (nbit < 8)       op = {op[6:0], ee_sdo};
            else if (nbit < 16) ad = {ad[6:0], ee_sdo};
            if (t_rise >= 0)
                chk(cyc - t_rise == 2 * HALF, "R4", "clock period", cyc - t_rise, 2 * HALF);
            t_rise = cyc;
            nbit++;
        end
        if (!ee_cs_n && sck_r && !ee_sck) begin
            chk(cyc - t_rise == HALF, "R4", "high time", cyc - t_rise, HALF);
            if ((op == 8'h03 && nbit == 16) || (op == 8'h05 && nbit == 8)) begin
                dout = (op == 8'h03) ? mem_f(ad) : STATUS_VAL;
                ee_sdi = dout[7];
                dbit = 1;
            end else if (dbit >= 1 && dbit <= 7) begin
                ee_sdi = dout[7 - dbit];
                dbit++;
            end
        end
        if (ee_cs_n && !sck_r && ee_sck) pre_cnt++;
        if (!cs_r && ee_cs_n) begin
            chk(ee_sck == 1'b0, "R5", "clock at release", ee_sck, 0);
            t_csr = cyc;
            gap_live = busy;
            if (exp_op_q.size() == 0) begin
                chk(0, "R6", "unexpected frame", op, 0);
            end else begin
                int eo, ea;
                eo = exp_op_q.pop_front();
                ea = exp_ad_q.pop_front();
                chk(op == eo, (eo == 5) ? "R8" : "R2", "command", op, eo);
                chk(nbit == ((eo == 5) ? 16 : 24), (eo == 5) ? "R8" : "R3", "clock count",
                    nbit, (eo == 5) ? 16 : 24);
                if (ea >= 0) chk(ad == ea, "R6", "address", ad, ea);
            end
        end
        // byte and completion scoreboard
        if (byte_valid) begin
            if (exp_byte_q.size() == 0) chk(0, "R11", "extra byte", byte_data, 0);
            else begin
                int eb;
                eb = exp_byte_q.pop_front();
                chk(byte_data == eb, "R3", "byte", byte_data, eb);
            end
        end
        if (done) begin
            done_cnt++;
            chk(exp_byte_q.size() == 0, "R9", "bytes left at done", exp_byte_q.size(), 0);
            chk(!busy, "R9", "busy at done", busy, 0);
        end
        sck_r = ee_sck;
        cs_r  = ee_cs_n;
    end

    task automatic run_req(input bit st, input logic [7:0] off, input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] a;
            a = off + 8'(i);
            exp_byte_q.push_back(st ? STATUS_VAL : mem_f(a));
            exp_op_q.push_back(st ? 5 : 3);
            exp_ad_q.push_back(st ? -1 : int'(a));
        end
        while (busy) @(negedge clk);
        status_mode = st; offset = off; count = 8'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ee_cs_n == 1'b1, "R1", "cs_n after reset", ee_cs_n, 1);
        chk(ee_sck == 1'b0, "R1", "sck after reset", ee_sck, 0);
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10 zero count: done next cycle, nothing on the wire
        offset = 8'h33; count = 8'h00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R10", "done after empty start", done, 1);
        chk(busy == 1'b0, "R10", "busy after empty start", busy, 0);
        repeat (20) @(negedge clk);
        chk(pre_cnt == 0, "R10", "preamble pulses", pre_cnt, 0);
        chk(ee_cs_n == 1'b1 && ee_sck == 1'b0, "R10", "lines idle", {ee_cs_n, ee_sck}, 2);

        // first read: preamble then three bytes
        run_req(1'b0, 8'h10, 3);
        chk(pre_cnt == 2, "R7", "preamble pulses", pre_cnt, 2);
        chk(ee_cs_n == 1'b1 && ee_sck == 1'b0 && !busy, "R1", "idle after request",
            {ee_cs_n, ee_sck, busy}, 4);

        // R6 wrap across 0xFF
        run_req(1'b0, 8'hFE, 4);
        chk(pre_cnt == 2, "R7", "no second preamble", pre_cnt, 2);

        // R8 status reads
        run_req(1'b1, 8'h00, 2);

        // R11 start while busy is ignored
        begin
            int dc;
            dc = done_cnt;
            for (int i = 0; i < 2; i++) begin
                exp_byte_q.push_back(mem_f(8'h40 + 8'(i)));
                exp_op_q.push_back(3);
                exp_ad_q.push_back(8'h40 + i);
            end
            status_mode = 1'b0; offset = 8'h40; count = 8'd2; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (60) @(negedge clk);
            offset = 8'h80; count = 8'd5; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (!done) @(negedge clk);
            repeat (200) @(negedge clk);
            chk(done_cnt == dc + 1, "R11", "done pulses", done_cnt - dc, 1);
            chk(!busy && ee_cs_n, "R11", "idle after ignored start", busy, 0);
        end

        // single byte at offset 0
        run_req(1'b0, 8'h00, 1);
        chk(exp_op_q.size() == 0, "R6", "frames outstanding", exp_op_q.size(), 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule